// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block locates the first PHY that answers on a shared management bus. A start pulse launches a scan. The scanner waits a programmable settling time, then walks every bus address from the lowest to the highest. At each address it reads the first identifier register. The read goes out through a request/response port that a separate management master serves.

A reply of all ones means the address is vacant, and the scanner moves to the next address. Any other reply means a PHY is present. The scanner then reads the second identifier register at that same address and stops. The two replies are joined into a 32-bit identifier, and a version with the revision nibble cleared is offered for matching against known device types.

If a full sweep finds nothing, the scanner waits again and repeats, up to a fixed number of sweeps. This gives a PHY that is slow to leave reset a window in which to appear. After the last empty sweep, the block reports a not-found result.

Top module: `phy_scan`

## Requirements
- R1: After reset, done, found, not_found and mgmt_req are 0, phy_addr is all ones (6'h3F) and phy_id is 0.
- R2: Within a sweep, identifier-1 reads (mgmt_reg = 2) are issued at addresses 0, 1, 2, … in ascending order. Each request is a one-cycle mgmt_req pulse, and the next request is not issued until the previous response has arrived.
- R3: An identifier-1 response of 16'hFFFF marks the address as vacant. The scan continues at the next address.
- R4: Any other identifier-1 response is followed by exactly one identifier-2 read (mgmt_reg = 3) at the same address. The result is phy_id = {identifier-1 reply, identifier-2 reply}.
- R5: The scan stops at the first responding address. No request is issued after the identifier-2 read. The block reports found = 1, not_found = 0, and phy_addr = {1'b0, address}.
- R6: Every sweep starts with a wait of WAIT_MS × CLK_PER_MS cycles. The first request of a scan goes out exactly that many cycles after the clock edge that samples start.
- R7: At most NPASS sweeps are made (11 by default). A PHY that first answers during the last sweep is found. One that would answer only in a later sweep is not.
- R8: If all sweeps find nothing, the block reports not_found = 1, found = 0 and phy_addr = all ones (6'h3F), after exactly NPASS × 32 identifier-1 reads and no identifier-2 read.
- R9: start is ignored while a scan is in progress. It neither restarts the scan nor causes a second done.
- R10: done is a single-cycle pulse at the end of each scan. The result outputs change only at that point and hold until the next scan ends.
- R11: phy_type equals phy_id with its low 4 bits (the revision) forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (sampled only when idle) |
| mgmt_req | output | 1 | One-cycle read request to the management master |
| mgmt_phy | output | 5 | PHY address of the request |
| mgmt_reg | output | 5 | Register index of the request (2 or 3) |
| rsp_valid | input | 1 | Read response strobe from the master |
| rsp_data | input | 16 | Read response data |
| done | output | 1 | Scan finished (one cycle) |
| found | output | 1 | A PHY was located |
| not_found | output | 1 | All sweeps ended empty |
| phy_addr | output | 6 | Located address; all ones when nothing was found |
| phy_id | output | 32 | Identifier {reg 2, reg 3} |
| phy_type | output | 32 | Identifier with revision nibble cleared |

## Verification
The bench places a single PHY at address 0, in the middle of the range, and at address 31. These cases separate correct ascending sweeps from early termination or an off-by-one at the top of the range. Placing two PHYs shows that the lower address wins and that no request follows the identifier-2 read. A PHY that wakes only after a chosen number of probes shows that the sweeps repeat: if it wakes in the final sweep it is found, and if it would wake one sweep later it is reported absent. An empty bus produces the not-found encoding after the exact read count. Start pulses injected during the wait and during the reads must leave the read count, the result and the single done pulse unchanged.

// File: rtl/phy_scan.sv
module phy_scan #(
  parameter int NADDR      = 32,
  parameter int NPASS      = 11,
  parameter int WAIT_MS    = 10,
  parameter int CLK_PER_MS = 100000,
  parameter int REG_ID1    = 2,
  parameter int REG_ID2    = 3,
  localparam int AW        = $clog2(NADDR),
  localparam int WAIT_CYC  = WAIT_MS * CLK_PER_MS,
  localparam int CW        = $clog2(WAIT_CYC + 1),
  localparam int PW        = $clog2(NPASS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          mgmt_req,
  output logic [AW-1:0] mgmt_phy,
  output logic [4:0]    mgmt_reg,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_data,
  output logic          done,
  output logic          found,
  output logic          not_found,
  output logic [AW:0]   phy_addr,
  output logic [31:0]   phy_id,
  output logic [31:0]   phy_type
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RD1, S_W1, S_RD2, S_W2, S_FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pass;
  logic [AW-1:0] cur;
  logic [15:0]   id_hi;

  wire vacant   = (rsp_data == 16'hFFFF);
  wire last_adr = (cur == AW'(NADDR - 1));
  wire last_pas = (pass == PW'(NPASS - 1));

  assign mgmt_req = (st == S_RD1) || (st == S_RD2);
  assign mgmt_phy = cur;
  assign mgmt_reg = (st == S_RD2 || st == S_W2) ? 5'(REG_ID2) : 5'(REG_ID1);
  assign done     = (st == S_FIN);
  assign phy_type = {phy_id[31:4], 4'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      pass      <= '0;
      cur       <= '0;
      id_hi     <= '0;
      found     <= 1'b0;
      not_found <= 1'b0;
      phy_addr  <= '1;
      phy_id    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st   <= S_WAIT;
          cnt  <= '0;
          pass <= '0;
        end
        S_WAIT: if (cnt == CW'(WAIT_CYC - 1)) begin
          cnt <= '0;
          cur <= '0;
          st  <= S_RD1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_RD1: st <= S_W1;
        S_W1: if (rsp_valid) begin
          if (!vacant) begin
            id_hi <= rsp_data;
            st    <= S_RD2;
          end else if (!last_adr) begin
            cur <= cur + 1'b1;
            st  <= S_RD1;
          end else if (!last_pas) begin
            pass <= pass + 1'b1;
            st   <= S_WAIT;
          end else begin
            found     <= 1'b0;
            not_found <= 1'b1;
            phy_addr  <= '1;
            phy_id    <= '0;
            st        <= S_FIN;
          end
        end
        S_RD2: st <= S_W2;
        S_W2: if (rsp_valid) begin
          found     <= 1'b1;
          not_found <= 1'b0;
          phy_addr  <= {1'b0, cur};
          phy_id    <= {id_hi, rsp_data};
          st        <= S_FIN;
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_scan_chk.sv
module phy_scan_chk #(
  parameter int AW  = 5,
  parameter int ID1 = 2,
  parameter int ID2 = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mgmt_req,
  input logic [AW-1:0] mgmt_phy,
  input logic [4:0]    mgmt_reg,
  input logic          done,
  input logic          found,
  input logic          not_found,
  input logic [AW:0]   phy_addr
);

  logic          have_last;
  logic [AW-1:0] last_phy;
  logic [4:0]    last_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_phy  <= '0;
      last_reg  <= '0;
    end else if (mgmt_req) begin
      have_last <= 1'b1;
      last_phy  <= mgmt_phy;
      last_reg  <= mgmt_reg;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_req |=> !mgmt_req);

  // R2
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_reg == 5'(ID1) && have_last && last_reg == 5'(ID1))
      |-> (mgmt_phy == last_phy + AW'(1) || mgmt_phy == '0));

  // R4
  id2_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_reg == 5'(ID2))
      |-> (have_last && last_reg == 5'(ID1) && mgmt_phy == last_phy));

  // R8
  notfound_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_found |-> (!found && (&phy_addr)));

  // R5
  found_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (!not_found && !phy_addr[AW]));

  // R10
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mgmt_req);

endmodule

bind phy_scan phy_scan_chk #(.AW(AW), .ID1(REG_ID1), .ID2(REG_ID2)) u_chk (
  .clk(clk), .rst_n(rst_n), .mgmt_req(mgmt_req), .mgmt_phy(mgmt_phy),
  .mgmt_reg(mgmt_reg), .done(done), .found(found), .not_found(not_found),
  .phy_addr(phy_addr)
);

// File: tb/sim_phy_scan.sv
`timescale 1ns/1ps
module sim_phy_scan;
  localparam int CPM  = 2;
  localparam int WMS  = 10;
  localparam int W    = CPM * WMS;
  localparam int NP   = 11;
  localparam int LAT  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mgmt_req;
  logic [4:0]  mgmt_phy;
  logic [4:0]  mgmt_reg;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = 16'h0;
  logic        done, found, not_found;
  logic [5:0]  phy_addr;
  logic [31:0] phy_id, phy_type;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  phy_scan #(.NPASS(NP), .WAIT_MS(WMS), .CLK_PER_MS(CPM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mgmt_req(mgmt_req), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .found(found), .not_found(not_found),
    .phy_addr(phy_addr), .phy_id(phy_id), .phy_type(phy_type));

  logic        present [32];
  int          wake    [32];
  logic [15:0] id1     [32];
  logic [15:0] id2     [32];
  int          rd_cnt  [32];
  int n_id1, n_id2, pend, order_err, id2_err;
  logic [4:0]  exp_addr, last_id1_addr;
  logic [15:0] resp;

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = resp;
      end
    end
    if (mgmt_req) begin
      if (mgmt_reg == 5'd2) begin
        if (mgmt_phy != exp_addr) order_err = order_err + 1;
        exp_addr      = mgmt_phy + 5'd1;
        last_id1_addr = mgmt_phy;
        n_id1         = n_id1 + 1;
        rd_cnt[mgmt_phy] = rd_cnt[mgmt_phy] + 1;
        resp = (present[mgmt_phy] && rd_cnt[mgmt_phy] > wake[mgmt_phy]) ? id1[mgmt_phy] : 16'hFFFF;
      end else begin
        if (mgmt_reg != 5'd3 || mgmt_phy != last_id1_addr) id2_err = id2_err + 1;
        n_id2 = n_id2 + 1;
        resp  = id2[mgmt_phy];
      end
      pend = LAT;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_clear();
    for (int i = 0; i < 32; i++) begin
      present[i] = 1'b0; wake[i] = 0; rd_cnt[i] = 0;
      id1[i] = 16'h0; id2[i] = 16'h0;
    end
    n_id1 = 0; n_id2 = 0; order_err = 0; id2_err = 0; exp_addr = 5'd0;
  endtask

  task automatic put_phy(input int a, input logic [15:0] h, input logic [15:0] l, input int wk);
    present[a] = 1'b1; id1[a] = h; id2[a] = l; wake[a] = wk;
  endtask

  int first_req, dones;

  task automatic run_scan(input bit poke);
    int k;
    bit seen_req;
    k = 0; seen_req = 0; first_req = -1; dones = 0;
    @(negedge clk); start = 1'b1;
    forever begin
      @(negedge clk);
      k++;
      start = poke && (k == 5 || k == W + 10 || k == W + 40);
      if (mgmt_req && !seen_req) begin seen_req = 1; first_req = k; end
      if (done) begin dones++; break; end
      if (k > 20000) begin
        errors++;
        $display("FAIL R10: scan never finished");
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
    check("R10 done single cycle", done, 0);
    for (int j = 0; j < W + 8; j++) begin
      if (done) dones++;
      if (mgmt_req) check("R9 no request after end", 1, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 found", found, 0);
    check("R1 not_found", not_found, 0);
    check("R1 req", mgmt_req, 0);
    check("R1 addr", phy_addr, 6'h3F);
    check("R1 id", phy_id, 0);
  endtask

  task automatic t_addr0();
    bus_clear(); put_phy(0, 16'h7810, 16'h0003, 0);
    run_scan(0);
    check("R6 first request delay", first_req, W + 1);
    check("R5 found", found, 1);
    check("R5 addr", phy_addr, 0);
    check("R4 id", phy_id, 32'h78100003);
    check("R4 id2 reads", n_id2, 1);
    check("R5 id1 reads", n_id1, 1);
    check("R10 one done", dones, 1);
  endtask

  task automatic t_mid();
    bus_clear(); put_phy(13, 16'h0022, 16'h1457, 0);
    run_scan(0);
    check("R3 id1 reads", n_id1, 14);
    check("R2 order", order_err, 0);
    check("R5 addr", phy_addr, 13);
    check("R4 id", phy_id, 32'h00221457);
    check("R11 type", phy_type, 32'h00221450);
    check("R4 id2 addr", id2_err, 0);
  endtask

  task automatic t_two();
    bus_clear(); put_phy(7, 16'h0181, 16'hB88A, 0); put_phy(20, 16'h1234, 16'h5678, 0);
    run_scan(0);
    check("R5 first responder", phy_addr, 7);
    check("R5 stop after find", n_id1, 8);
    check("R11 type", phy_type, 32'h0181B880);
    check("R5 not_found clear", not_found, 0);
  endtask

  task automatic t_top();
    bus_clear(); put_phy(31, 16'h02A8, 16'h0154, 0);
    run_scan(0);
    check("R2 top address", phy_addr, 31);
    check("R2 reads", n_id1, 32);
    check("R2 order", order_err, 0);
  endtask

  task automatic t_late(input int wk, input int exp_reads, input bit exp_found);
    bus_clear(); put_phy(5, 16'h0016, 16'hF87C, wk);
    run_scan(0);
    check("R7 found", found, exp_found);
    check("R7 id1 reads", n_id1, exp_reads);
    check("R7 order", order_err, 0);
    if (exp_found) check("R7 addr", phy_addr, 5);
  endtask

  task automatic t_empty();
    bus_clear();
    run_scan(0);
    check("R8 not_found", not_found, 1);
    check("R8 found", found, 0);
    check("R8 addr", phy_addr, 6'h3F);
    check("R8 reads", n_id1, NP * 32);
    check("R8 no id2", n_id2, 0);
  endtask

  task automatic t_busy();
    bus_clear(); put_phy(13, 16'h0022, 16'h1457, 0);
    run_scan(1);
    check("R9 read count", n_id1, 14);
    check("R9 single done", dones, 1);
    check("R9 addr", phy_addr, 13);
    check("R6 first request delay", first_req, W + 1);
  endtask

  initial begin
    bus_clear(); pend = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr0();
    t_mid();
    t_two();
    t_top();
    t_late(3, 3 * 32 + 6, 1);
    t_late(NP - 1, (NP - 1) * 32 + 6, 1);
    t_late(NP, NP * 32, 0);
    t_empty();
    check("R10 results held", phy_addr, 6'h3F);
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10: watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule